// File: doc/BRIEF.md
# Dual-clock mailbox bridge

This block carries single 36-bit words between two ports that run on unrelated clocks, alongside a FIFO but separate from its storage. Mailbox 1 is loaded from port A and read on port B. Mailbox 2 is loaded from port B and read on port A. Each mailbox has two active-low "mail waiting" flags. The reader-side flag tells the receiving port that an unread word is present. The writer-side flag tells the sending port that its last word has not yet been taken.

Each port has a chip-select (active low), a write/read direction bit, an enable and a mailbox-select. The block decodes these into FIFO push or pop strobes for the external FIFO, and into mailbox load or take operations. It also drives each port's read data. Port A always presents mailbox 2. Port B presents either the FIFO output word or mailbox 1, as the mailbox-select input chooses. Set and clear events cross between the clock domains as toggles through flop synchronisers, so no event is lost.

Top module: `mbx_bridge`

## Requirements
- R1: While rst_ni is low, and after it is released with no traffic, all four mailbox flags are high. Both output-enables are low and both data outputs are zero.
- R2: On port A, with chip-select low, direction high (write), enable high and mailbox-select low, a_push_o is high. It is low if chip-select is high or enable is low.
- R3: On port B, with chip-select low, direction low (read), enable high and mailbox-select low, b_pop_o is high. It is low if chip-select is high or enable is low.
- R4: A port's output-enable is high exactly when its chip-select is low and its direction bit is low. While the output-enable is low, that port's data output is zero.
- R5: While a_oe_o is high, a_data_o equals the word stored in mailbox 2.
- R6: While b_oe_o is high, b_data_o equals b_fifo_q_i if b_mbx_i is low, and equals the word stored in mailbox 1 if b_mbx_i is high.
- R7: A mailbox load (chip-select low, direction high, enable high, mailbox-select high) stores the data word. If the writer-side flag was high, that flag is low after the same writer clock edge.
- R8: After a load, the reader-side flag goes low within three reader clock edges of the writer edge that made the load.
- R9: A mailbox take (chip-select low, direction low, enable high, mailbox-select high) while the reader-side flag is low drives that flag high at the same reader edge. The writer-side flag returns high after the acknowledgement crosses back.
- R10: A take while the reader-side flag is high, or any cycle with chip-select high or enable low, changes neither flag nor any stored word.
- R11: A load while the writer-side flag is already low replaces the stored word. It then schedules exactly one more notification: after the outstanding take is acknowledged, the reader-side flag falls once more.
- R12: The two mailboxes work independently. Loads and takes on both of them in overlapping cycles each behave as in R7 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous reset, active low, shared by both domains |
| a_cs_ni | input | 1 | Port A chip-select, active low |
| a_wr_i | input | 1 | Port A direction: 1 write, 0 read |
| a_en_i | input | 1 | Port A operation enable |
| a_mbx_i | input | 1 | Port A mailbox-select |
| a_data_i | input | 36 | Port A write data |
| a_data_o | output | 36 | Port A read data (mailbox 2) |
| a_oe_o | output | 1 | Port A output-enable |
| a_push_o | output | 1 | FIFO push strobe, port A domain |
| a_mb1_busy_no | output | 1 | Mailbox 1 writer-side flag, active low |
| a_mb2_pend_no | output | 1 | Mailbox 2 reader-side flag, active low |
| b_cs_ni | input | 1 | Port B chip-select, active low |
| b_wr_i | input | 1 | Port B direction: 1 write, 0 read |
| b_en_i | input | 1 | Port B operation enable |
| b_mbx_i | input | 1 | Port B mailbox-select; also steers b_data_o |
| b_data_i | input | 36 | Port B write data |
| b_fifo_q_i | input | 36 | FIFO output word from the external FIFO |
| b_data_o | output | 36 | Port B read data (FIFO word or mailbox 1) |
| b_oe_o | output | 1 | Port B output-enable |
| b_pop_o | output | 1 | FIFO pop strobe, port B domain |
| b_mb1_pend_no | output | 1 | Mailbox 1 reader-side flag, active low |
| b_mb2_busy_no | output | 1 | Mailbox 2 writer-side flag, active low |

## Verification
The two functions that can coincide are a take on the reader port and a new load on the writer port. This happens while the take's acknowledgement is still crossing back, so the writer still sees the mailbox as occupied. The bench provokes this by issuing a port-A load on the first port-A edge after a port-B take. It also issues loads that overwrite a word that has not yet been taken. The result is judged at the ports. The new word must raise the reader flag once more, and the following take must return the newest word. After that, the reader flag must stay high for many cycles, which shows that exactly one notification is produced and no spurious second one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic fifo_wr;
    logic fifo_rd;
    logic mbx_wr;
    logic mbx_rd;
    logic oe;
  } port_op_t;

  function automatic port_op_t decode_op(input logic cs_n, input logic wr,
                                         input logic en, input logic mbx);
    port_op_t op;
    logic act;
    act        = !cs_n && en;
    op.fifo_wr = act && wr && !mbx;
    op.fifo_rd = act && !wr && !mbx;
    op.mbx_wr  = act && wr && mbx;
    op.mbx_rd  = act && !wr && mbx;
    op.oe      = !cs_n && !wr;
    return op;
  endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int unsigned DW       = 36,
  parameter bit          FIFO_SRC = 1'b0
) (
  input  logic          cs_ni,
  input  logic          wr_i,
  input  logic          en_i,
  input  logic          mbx_i,
  input  logic [DW-1:0] mbx_q_i,
  input  logic [DW-1:0] fifo_q_i,
  output port_op_t      op_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] sel;

  assign op_o = decode_op(cs_ni, wr_i, en_i, mbx_i);

  generate
    if (FIFO_SRC) begin : g_mux
      // mailbox-select steers the read path as well as the operation
      assign sel = mbx_i ? mbx_q_i : fifo_q_i;
    end else begin : g_mbx_only
      logic fifo_unused;
      assign fifo_unused = ^fifo_q_i;
      assign sel = mbx_q_i;
    end
  endgenerate

  assign data_o = op_o.oe ? sel : '0;
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int unsigned DW          = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          pend_no,
  output logic          busy_no
);
  logic          wr_tgl, ack_s, rearm, busy;
  logic          rd_tgl, wr_s, pend;
  logic [DW-1:0] word_q;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_tgl), .q_o(wr_s));
  mbx_sync #(.STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_tgl), .q_o(ack_s));

  assign busy = wr_tgl ^ ack_s;
  assign pend = wr_s ^ rd_tgl;

  // writer domain: a load while busy only overwrites and re-arms one notice
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_tgl <= 1'b0;
      rearm  <= 1'b0;
      word_q <= '0;
    end else begin
      if (wr_i) word_q <= wdata_i;
      if (wr_i || rearm) begin
        if (!busy) begin
          wr_tgl <= ~wr_tgl;
          rearm  <= 1'b0;
        end else if (wr_i) begin
          rearm  <= 1'b1;
        end
      end
    end
  end

  // reader domain
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rd_tgl <= 1'b0;
    else if (rd_i && pend) rd_tgl <= ~rd_tgl;
  end

  assign rdata_o = word_q;
  assign pend_no = ~pend;
  assign busy_no = ~(busy | rearm);

  // R7
  wr_first_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_i && busy_no) |=> !busy_no);
  // R9
  rd_clear_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_i && !pend_no) |=> pend_no);
  // R8
  pend_fall_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $fell(pend_no) |-> (wr_s != $past(wr_s)));
  // R10
  idle_rd_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_i && pend_no) |=> $stable(rd_tgl));
  // R11
  rearm_fire_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (rearm && !busy) |=> (busy && !rearm));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned DW          = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          a_cs_ni,
  input  logic          a_wr_i,
  input  logic          a_en_i,
  input  logic          a_mbx_i,
  input  logic [DW-1:0] a_data_i,
  output logic [DW-1:0] a_data_o,
  output logic          a_oe_o,
  output logic          a_push_o,
  output logic          a_mb1_busy_no,
  output logic          a_mb2_pend_no,
  input  logic          b_cs_ni,
  input  logic          b_wr_i,
  input  logic          b_en_i,
  input  logic          b_mbx_i,
  input  logic [DW-1:0] b_data_i,
  input  logic [DW-1:0] b_fifo_q_i,
  output logic [DW-1:0] b_data_o,
  output logic          b_oe_o,
  output logic          b_pop_o,
  output logic          b_mb1_pend_no,
  output logic          b_mb2_busy_no
);
  port_op_t      a_op, b_op;
  logic [DW-1:0] mb1_q, mb2_q;
  logic          op_unused;

  mbx_port #(.DW(DW), .FIFO_SRC(1'b0)) u_pa (
    .cs_ni(a_cs_ni), .wr_i(a_wr_i), .en_i(a_en_i), .mbx_i(a_mbx_i),
    .mbx_q_i(mb2_q), .fifo_q_i('0), .op_o(a_op), .data_o(a_data_o));

  mbx_port #(.DW(DW), .FIFO_SRC(1'b1)) u_pb (
    .cs_ni(b_cs_ni), .wr_i(b_wr_i), .en_i(b_en_i), .mbx_i(b_mbx_i),
    .mbx_q_i(mb1_q), .fifo_q_i(b_fifo_q_i), .op_o(b_op), .data_o(b_data_o));

  mbx_chan #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mb1 (
    .wclk_i(clk_a_i), .rclk_i(clk_b_i), .rst_ni(rst_ni),
    .wr_i(a_op.mbx_wr), .wdata_i(a_data_i), .rd_i(b_op.mbx_rd),
    .rdata_o(mb1_q), .pend_no(b_mb1_pend_no), .busy_no(a_mb1_busy_no));

  mbx_chan #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mb2 (
    .wclk_i(clk_b_i), .rclk_i(clk_a_i), .rst_ni(rst_ni),
    .wr_i(b_op.mbx_wr), .wdata_i(b_data_i), .rd_i(a_op.mbx_rd),
    .rdata_o(mb2_q), .pend_no(a_mb2_pend_no), .busy_no(b_mb2_busy_no));

  assign a_push_o  = a_op.fifo_wr;
  assign a_oe_o    = a_op.oe;
  assign b_pop_o   = b_op.fifo_rd;
  assign b_oe_o    = b_op.oe;
  assign op_unused = a_op.fifo_rd ^ b_op.fifo_wr;

  // R1
  rst_flags_chk: assert property (@(posedge clk_a_i)
    !rst_ni |-> (a_mb1_busy_no && a_mb2_pend_no && b_mb1_pend_no && b_mb2_busy_no));
endmodule

// File: tb/sim_mbx_bridge.sv
`timescale 1ns/100ps
module sim_mbx_bridge;
  localparam int DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_ni = 1'b0;
  logic a_cs_ni, a_wr_i, a_en_i, a_mbx_i;
  logic b_cs_ni, b_wr_i, b_en_i, b_mbx_i;
  logic [DW-1:0] a_data_i, b_data_i, b_fifo_q_i, a_data_o, b_data_o;
  logic a_oe_o, a_push_o, a_mb1_busy_no, a_mb2_pend_no;
  logic b_oe_o, b_pop_o, b_mb1_pend_no, b_mb2_busy_no;

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] mb1_model = '0, mb2_model = '0;
  logic [DW-1:0] q1[$], q2[$];

  always #4 clk_a = ~clk_a;      // 125 MHz
  always #6.5 clk_b = ~clk_b;

  mbx_bridge u0 (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni),
    .a_cs_ni(a_cs_ni), .a_wr_i(a_wr_i), .a_en_i(a_en_i), .a_mbx_i(a_mbx_i),
    .a_data_i(a_data_i), .a_data_o(a_data_o), .a_oe_o(a_oe_o), .a_push_o(a_push_o),
    .a_mb1_busy_no(a_mb1_busy_no), .a_mb2_pend_no(a_mb2_pend_no),
    .b_cs_ni(b_cs_ni), .b_wr_i(b_wr_i), .b_en_i(b_en_i), .b_mbx_i(b_mbx_i),
    .b_data_i(b_data_i), .b_fifo_q_i(b_fifo_q_i), .b_data_o(b_data_o), .b_oe_o(b_oe_o),
    .b_pop_o(b_pop_o), .b_mb1_pend_no(b_mb1_pend_no), .b_mb2_busy_no(b_mb2_busy_no));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic idle_a(); a_cs_ni = 1; a_wr_i = 0; a_en_i = 0; a_mbx_i = 0; endtask
  task automatic idle_b(); b_cs_ni = 1; b_wr_i = 0; b_en_i = 0; b_mbx_i = 0; endtask

  task automatic op_a(input logic wr, input logic mbx, input logic [DW-1:0] d);
    @(posedge clk_a); #1;
    a_cs_ni = 0; a_wr_i = wr; a_en_i = 1; a_mbx_i = mbx; a_data_i = d;
    @(posedge clk_a); #1;
    idle_a();
  endtask

  task automatic op_b(input logic wr, input logic mbx, input logic [DW-1:0] d);
    @(posedge clk_b); #1;
    b_cs_ni = 0; b_wr_i = wr; b_en_i = 1; b_mbx_i = mbx; b_data_i = d;
    @(posedge clk_b); #1;
    idle_b();
  endtask

  // driver side of the scoreboard
  task automatic mb1_write(input logic [DW-1:0] d); mb1_model = d; op_a(1, 1, d); endtask
  task automatic mb2_write(input logic [DW-1:0] d); mb2_model = d; op_b(1, 1, d); endtask
  task automatic mb1_read(); q1.push_back(mb1_model); op_b(0, 1, '0); endtask
  task automatic mb2_read(); q2.push_back(mb2_model); op_a(0, 1, '0); endtask

  // monitors: compare data presented during each mailbox take
  always @(negedge clk_b) begin
    if (!b_cs_ni && !b_wr_i && b_en_i && b_mbx_i) begin
      if (q1.size() == 0) chk("R6 mb1 take unexpected", 1, 0);
      else chk("R6/R9 mb1 take data", b_data_o, q1.pop_front());
    end
  end
  always @(negedge clk_a) begin
    if (!a_cs_ni && !a_wr_i && a_en_i && a_mbx_i) begin
      if (q2.size() == 0) chk("R5 mb2 take unexpected", 1, 0);
      else chk("R5/R9 mb2 take data", a_data_o, q2.pop_front());
    end
  end

  function automatic logic flag(input int sel);
    case (sel)
      0: return b_mb1_pend_no;
      1: return a_mb1_busy_no;
      2: return a_mb2_pend_no;
      default: return b_mb2_busy_no;
    endcase
  endfunction

  task automatic wait_flag(input int sel, input logic val, input int maxc);
    int n = 0;
    while (flag(sel) !== val && n < maxc) begin
      if (sel == 1 || sel == 2) @(negedge clk_a); else @(negedge clk_b);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    total++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    idle_a(); idle_b();
    a_data_i = '0; b_data_i = '0; b_fifo_q_i = '0;
    repeat (3) @(posedge clk_a);
    #1;
    // R1 during reset
    chk("R1 flags in reset", {a_mb1_busy_no, a_mb2_pend_no, b_mb1_pend_no, b_mb2_busy_no}, 4'hF);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_b);
    #1;
    chk("R1 flags after reset", {a_mb1_busy_no, a_mb2_pend_no, b_mb1_pend_no, b_mb2_busy_no}, 4'hF);
    chk("R1 oe low", {a_oe_o, b_oe_o}, 0);
    chk("R1 data zero", a_data_o | b_data_o, 0);

    // R2 port A decode
    @(posedge clk_a); #1;
    a_cs_ni = 0; a_wr_i = 1; a_en_i = 1; a_mbx_i = 0; #1;
    chk("R2 push strobe", a_push_o, 1);
    chk("R4 oe low on write", a_oe_o, 0);
    a_cs_ni = 1; #1; chk("R2 cs high no push", a_push_o, 0);
    a_cs_ni = 0; a_en_i = 0; #1; chk("R2 en low no push", a_push_o, 0);
    idle_a();

    // R3, R4, R6 port B decode and FIFO path
    @(posedge clk_b); #1;
    b_fifo_q_i = 36'hA_5A5A_C3C3;
    b_cs_ni = 0; b_wr_i = 0; b_en_i = 1; b_mbx_i = 0; #1;
    chk("R3 pop strobe", b_pop_o, 1);
    chk("R4 oe high", b_oe_o, 1);
    chk("R6 fifo word", b_data_o, 36'hA_5A5A_C3C3);
    b_en_i = 0; #1; chk("R3 en low no pop", b_pop_o, 0);
    b_cs_ni = 1; b_en_i = 1; #1; chk("R3 cs high no pop", b_pop_o, 0);
    chk("R4 data zero when disabled", b_data_o, 0);
    idle_b();

    // R7, R8 load mailbox 1
    mb1_write(36'h1_2345_6789);
    chk("R7 writer flag low", a_mb1_busy_no, 0);
    wait_flag(0, 0, 4);
    chk("R8 reader flag low", b_mb1_pend_no, 0);

    // R10 disabled load on A must not touch mailbox 1
    @(posedge clk_a); #1;
    a_cs_ni = 1; a_wr_i = 1; a_en_i = 1; a_mbx_i = 1; a_data_i = 36'hF_FFFF_0000;
    repeat (2) @(posedge clk_a); #1;
    a_cs_ni = 0; a_en_i = 0;
    repeat (2) @(posedge clk_a); #1;
    idle_a();
    @(posedge clk_b); #1;
    b_cs_ni = 0; b_wr_i = 0; b_en_i = 0; b_mbx_i = 1; #1;
    chk("R10/R6 mb1 word kept", b_data_o, 36'h1_2345_6789);
    idle_b();

    // R9 take mailbox 1
    mb1_read();
    chk("R9 reader flag high", b_mb1_pend_no, 1);
    wait_flag(1, 1, 6);
    chk("R9 writer flag high", a_mb1_busy_no, 1);

    // R10 take of empty mailbox
    mb1_read();
    repeat (6) @(negedge clk_b);
    chk("R10 reader flag stays high", b_mb1_pend_no, 1);
    chk("R10 writer flag stays high", a_mb1_busy_no, 1);

    // R5 mailbox 2 path
    mb2_write(36'h0_ABCD_EF01);
    chk("R7 mb2 writer flag low", b_mb2_busy_no, 0);
    wait_flag(2, 0, 4);
    chk("R8 mb2 reader flag low", a_mb2_pend_no, 0);
    @(posedge clk_a); #1;
    a_cs_ni = 0; a_wr_i = 0; a_en_i = 0; a_mbx_i = 0; #1;
    chk("R5 port A shows mb2", a_data_o, 36'h0_ABCD_EF01);
    idle_a();
    mb2_read();
    chk("R9 mb2 reader flag high", a_mb2_pend_no, 1);
    wait_flag(3, 1, 6);
    chk("R9 mb2 writer flag high", b_mb2_busy_no, 1);

    // R11 overwrite before take
    mb1_write(36'h3_0000_0003);
    mb1_write(36'h4_0000_0004);
    chk("R11 writer flag still low", a_mb1_busy_no, 0);
    wait_flag(0, 0, 4);
    mb1_read();
    chk("R11 flag high after take", b_mb1_pend_no, 1);
    wait_flag(0, 0, 12);
    chk("R11 one more notice", b_mb1_pend_no, 0);
    mb1_read();
    wait_flag(1, 1, 8);
    repeat (10) @(negedge clk_b);
    chk("R11 no further notice", b_mb1_pend_no, 1);
    chk("R11 writer flag high", a_mb1_busy_no, 1);

    // R11 load landing while the take acknowledgement crosses
    mb1_write(36'h5_0000_0005);
    wait_flag(0, 0, 4);
    mb1_read();
    mb1_write(36'h6_0000_0006);
    wait_flag(0, 0, 12);
    chk("R11 window load notified", b_mb1_pend_no, 0);
    mb1_read();
    repeat (12) @(negedge clk_b);
    chk("R11 window single notice", b_mb1_pend_no, 1);

    // R12 both mailboxes in overlapping cycles
    fork
      mb1_write(36'h7_7777_7777);
      mb2_write(36'h8_8888_8888);
    join
    wait_flag(0, 0, 4);
    wait_flag(2, 0, 4);
    chk("R12 both pending", {b_mb1_pend_no, a_mb2_pend_no}, 0);
    fork
      mb1_read();
      mb2_read();
    join
    wait_flag(1, 1, 6);
    wait_flag(3, 1, 6);
    chk("R12 all flags high", {a_mb1_busy_no, a_mb2_pend_no, b_mb1_pend_no, b_mb2_busy_no}, 4'hF);
    chk("R12 queues drained", q1.size() + q2.size(), 0);

    report();
  end
endmodule